// File: doc/BRIEF.md
# Multi-Channel Event Timer Comparator

The block is a memory-mapped event timer: a single 64-bit up-counter shared by several comparator channels. Software presets the counter while it is stopped, sets the run bit, and programs each channel with a comparator value. When the counter reaches a channel's comparator, the channel signals an event. Depending on its configuration it pulses or holds an interrupt line, posts a message write (a data word sent to an address), or, when the legacy routing bit is set, drives one of two fixed legacy interrupt lines.

A channel may be one-shot or, if it supports it, periodic. A periodic channel moves its comparator forward by a programmed period on every match. The period is loaded through a set-value sequence: a configuration write with the set-value bit arms the channel, the next comparator write loads the comparator, and the write after that loads the period. Register access is a single-cycle 32-bit write port plus a combinational read mux.

Top module: `evtimer_top`

## Requirements
- R1: After reset the ID register at 0x000 reads channel count minus one in bits [12:8] and 0x01 in bits [7:0]. The counter reads 0, and all interrupt lines and the message request are low.
- R2: The counter low half (0x0F0) and high half (0x0F4) take writes only while the run bit is clear. Writes made while it runs are dropped.
- R3: While the run bit (general configuration 0x010, bit 0) is set, the counter rises by exactly one every clock cycle.
- R4: Channel n has its registers at 0x100 + 0x20*n: configuration at +0x00, comparator low at +0x08, comparator high at +0x0C, route data at +0x10 and route address at +0x14. The configuration bits are: 1 level trigger, 2 enable, 3 periodic, 6 set-value (reads 0), 8 32-bit compare and 14 message delivery. Bit 4 (periodic capable) and bit 15 (message capable) are read-only.
- R5: An enabled one-shot edge channel pulses its line for exactly one cycle, in the cycle after the counter equals its comparator. It does not fire again. A comparator value reads back as written.
- R6: With periodic and set-value written together, the next comparator-low write sets the comparator and the one after it sets the period. The comparator then advances by the period on every match.
- R7: A channel without periodic capability reads its periodic bit as 0 and behaves as one-shot.
- R8: A level channel sets bit n of the status register at 0x020 on a match. Its line follows that bit, which stays set until a 1 is written to it.
- R9: With general configuration bit 1 set, channel 0 events appear on the legacy tick line and channel 1 events on the legacy RTC line, and their own lines stay low.
- R10: A channel with message delivery enabled raises a one-cycle request carrying its route data and address instead of its line. On a channel without message capability, the message bit reads 0 and is ignored.
- R11: Message events that arrive in the same cycle are all delivered, one per cycle, lowest channel number first.
- R12: In 32-bit mode only the low 32 bits of counter and comparator are compared. Otherwise all 64 bits must match.
- R13: A match requires equality, so a comparator that is already behind the counter does not fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | NCH | Per-channel interrupt lines |
| leg_tick_o | output | 1 | Legacy line fed by channel 0 |
| leg_rtc_o | output | 1 | Legacy line fed by channel 1 |
| msg_valid_o | output | 1 | Message write request |
| msg_addr_o | output | 32 | Message destination address |
| msg_data_o | output | 32 | Message data word |

## Verification
The hardest states to reach from the ports are two message channels matching in the same cycle and a periodic channel several matches into its set-value sequence. Both need exact agreement between the counter and the comparators. The bench therefore presets the counter while it is stopped, places the comparators a short, known distance ahead, and then starts the counter. While it runs, it reads the counter on every cycle and records the value at which each line or request rises. The expected counter values come from comparator + 1 for the first event and from the period for the later ones.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
    localparam int CNT_W  = 64;
    localparam int WORD   = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_ID     = 12'h000;
    localparam logic [ADDR_W-1:0] A_GCFG   = 12'h010;
    localparam logic [ADDR_W-1:0] A_STAT   = 12'h020;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 12'h0F0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 12'h0F4;

    localparam logic [4:0] O_CFG    = 5'h00;
    localparam logic [4:0] O_CMP_LO = 5'h08;
    localparam logic [4:0] O_CMP_HI = 5'h0C;
    localparam logic [4:0] O_RT_D   = 5'h10;
    localparam logic [4:0] O_RT_A   = 5'h14;

    localparam int B_LVL  = 1;
    localparam int B_EN   = 2;
    localparam int B_PER  = 3;
    localparam int B_PCAP = 4;
    localparam int B_SETV = 6;
    localparam int B_M32  = 8;
    localparam int B_MSG  = 14;
    localparam int B_MCAP = 15;

    typedef struct packed {
        logic lvl;
        logic en;
        logic per;
        logic m32;
        logic msg;
    } ch_cfg_t;

    typedef enum logic [1:0] {SV_OFF, SV_CMP, SV_PER} sv_e;

    function automatic logic [WORD-1:0] cfg_word(ch_cfg_t c, logic pcap, logic mcap);
        logic [WORD-1:0] w;
        w = '0;
        w[B_LVL]  = c.lvl;
        w[B_EN]   = c.en;
        w[B_PER]  = c.per;
        w[B_PCAP] = pcap;
        w[B_M32]  = c.m32;
        w[B_MSG]  = c.msg;
        w[B_MCAP] = mcap;
        return w;
    endfunction
endpackage

// File: rtl/evtimer_counter.sv
module evtimer_counter
    import evtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [WORD-1:0]  wdata,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            if (wr_lo) cnt_q[WORD-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:WORD] <= wdata;
        end
    end

    // R2: a stopped counter with no write holds its value
    p_cnt_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt_q));

    // R3: a running counter steps by one
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
        run |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/evtimer_chan.sv
module evtimer_chan
    import evtimer_pkg::*;
#(
    parameter bit PER_OK = 1'b1,
    parameter bit MSG_OK = 1'b1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cfg_we,
    input  logic             cmp_lo_we,
    input  logic             cmp_hi_we,
    input  logic             rt_d_we,
    input  logic             rt_a_we,
    input  logic [WORD-1:0]  wdata,
    output ch_cfg_t          cfg_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic [WORD-1:0]  rt_data_q,
    output logic [WORD-1:0]  rt_addr_q,
    output logic             hit
);
    logic [WORD-1:0] period_q;
    sv_e             sv_q;
    logic            match;

    assign match = cfg_q.m32 ? (cnt[WORD-1:0] == cmp_q[WORD-1:0]) : (cnt == cmp_q);
    assign hit   = run & cfg_q.en & match;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            cmp_q     <= '0;
            period_q  <= '0;
            sv_q      <= SV_OFF;
            rt_data_q <= '0;
            rt_addr_q <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q.lvl <= wdata[B_LVL];
                cfg_q.en  <= wdata[B_EN];
                cfg_q.per <= PER_OK & wdata[B_PER];
                cfg_q.m32 <= wdata[B_M32];
                cfg_q.msg <= MSG_OK & wdata[B_MSG];
                sv_q      <= (PER_OK && wdata[B_PER] && wdata[B_SETV]) ? SV_CMP : SV_OFF;
            end
            if (cmp_lo_we) begin
                case (sv_q)
                    SV_CMP: begin
                        cmp_q[WORD-1:0] <= wdata;
                        sv_q            <= SV_PER;
                    end
                    SV_PER: begin
                        period_q <= wdata;
                        sv_q     <= SV_OFF;
                    end
                    default: cmp_q[WORD-1:0] <= wdata;
                endcase
            end else if (hit && cfg_q.per) begin
                if (cfg_q.m32) cmp_q[WORD-1:0] <= cmp_q[WORD-1:0] + period_q;
                else           cmp_q <= cmp_q + CNT_W'(period_q);
            end
            if (cmp_hi_we) cmp_q[CNT_W-1:WORD] <= wdata;
            if (rt_d_we)   rt_data_q <= wdata;
            if (rt_a_we)   rt_addr_q <= wdata;
        end
    end

    logic [WORD-1:0] wdata_unused;
    assign wdata_unused = wdata;

    // R5: the comparator only moves on a write or a periodic match
    p_cmp_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!cmp_lo_we && !cmp_hi_we && !(hit && cfg_q.per)) |=> $stable(cmp_q));
endmodule

// File: rtl/evtimer_msgarb.sv
module evtimer_msgarb #(
    parameter int NCH = 3
)(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] grant,
    output logic           valid
);
    logic [NCH-1:0] pend_q;

    assign grant = pend_q & (~pend_q + NCH'(1));
    assign valid = |pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~grant) | req;
    end

    // R11: a served request that is not renewed leaves the queue
    p_served_r11: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~req) != '0) |=> ((pend_q & $past(grant & ~req)) == '0));

    // R11: at most one channel is served per cycle
    p_one_grant_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
    import evtimer_pkg::*;
#(
    parameter int             NCH     = 3,
    parameter logic [NCH-1:0] PER_CAP = 3'b011,
    parameter logic [NCH-1:0] MSG_CAP = 3'b110
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD-1:0]   bus_wdata,
    output logic [WORD-1:0]   bus_rdata,
    output logic [NCH-1:0]    irq_o,
    output logic              leg_tick_o,
    output logic              leg_rtc_o,
    output logic              msg_valid_o,
    output logic [WORD-1:0]   msg_addr_o,
    output logic [WORD-1:0]   msg_data_o
);
    localparam int SEL_W = 3;

    logic              run_q, leg_q;
    logic [CNT_W-1:0]  cnt;
    logic [NCH-1:0]    status_q, evt_q, clr_mask;
    logic [NCH-1:0]    hit_v, to_msg, lvl_set, edge_set, line_v, grant;
    ch_cfg_t           cfg_a [NCH];
    logic [CNT_W-1:0]  cmp_a [NCH];
    logic [WORD-1:0]   rtd_a [NCH];
    logic [WORD-1:0]   rta_a [NCH];

    logic             ch_region, ch_wr;
    logic [SEL_W-1:0] ch_sel;
    logic [4:0]       ch_off;

    assign ch_region = (bus_addr[11:8] == 4'h1);
    assign ch_sel    = bus_addr[7:5];
    assign ch_off    = bus_addr[4:0];
    assign ch_wr     = bus_wr && ch_region;
    assign clr_mask  = (bus_wr && bus_addr == A_STAT) ? bus_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            leg_q    <= 1'b0;
            status_q <= '0;
            evt_q    <= '0;
        end else begin
            if (bus_wr && bus_addr == A_GCFG) {leg_q, run_q} <= bus_wdata[1:0];
            status_q <= (status_q & ~clr_mask) | lvl_set;
            evt_q    <= edge_set;
        end
    end

    evtimer_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run_q),
        .wr_lo (bus_wr && bus_addr == A_CNT_LO),
        .wr_hi (bus_wr && bus_addr == A_CNT_HI),
        .wdata (bus_wdata),
        .cnt_q (cnt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam bit LEG_SLOT = (g < 2);
        logic sel_me;
        assign sel_me = ch_wr && (ch_sel == SEL_W'(g));

        evtimer_chan #(.PER_OK(PER_CAP[g]), .MSG_OK(MSG_CAP[g])) u_ch (
            .clk       (clk),
            .rst       (rst),
            .run       (run_q),
            .cnt       (cnt),
            .cfg_we    (sel_me && ch_off == O_CFG),
            .cmp_lo_we (sel_me && ch_off == O_CMP_LO),
            .cmp_hi_we (sel_me && ch_off == O_CMP_HI),
            .rt_d_we   (sel_me && ch_off == O_RT_D),
            .rt_a_we   (sel_me && ch_off == O_RT_A),
            .wdata     (bus_wdata),
            .cfg_q     (cfg_a[g]),
            .cmp_q     (cmp_a[g]),
            .rt_data_q (rtd_a[g]),
            .rt_addr_q (rta_a[g]),
            .hit       (hit_v[g])
        );

        assign to_msg[g]   = cfg_a[g].msg & ~(leg_q & LEG_SLOT);
        assign lvl_set[g]  = hit_v[g] &  cfg_a[g].lvl & ~to_msg[g];
        assign edge_set[g] = hit_v[g] & ~cfg_a[g].lvl & ~to_msg[g];
        assign line_v[g]   = evt_q[g] | status_q[g];
        assign irq_o[g]    = line_v[g] & ~(leg_q & LEG_SLOT);
    end

    assign leg_tick_o = leg_q & line_v[0];
    assign leg_rtc_o  = leg_q & line_v[1];

    evtimer_msgarb #(.NCH(NCH)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (hit_v & to_msg),
        .grant (grant),
        .valid (msg_valid_o)
    );

    always_comb begin
        msg_data_o = '0;
        msg_addr_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grant[i]) begin
                msg_data_o = rtd_a[i];
                msg_addr_o = rta_a[i];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (ch_region) begin
            if (int'(ch_sel) < NCH) begin
                case (ch_off)
                    O_CFG:    bus_rdata = cfg_word(cfg_a[ch_sel], PER_CAP[ch_sel], MSG_CAP[ch_sel]);
                    O_CMP_LO: bus_rdata = cmp_a[ch_sel][WORD-1:0];
                    O_CMP_HI: bus_rdata = cmp_a[ch_sel][CNT_W-1:WORD];
                    O_RT_D:   bus_rdata = rtd_a[ch_sel];
                    O_RT_A:   bus_rdata = rta_a[ch_sel];
                    default:  bus_rdata = '0;
                endcase
            end
        end else begin
            case (bus_addr)
                A_ID:     bus_rdata = {19'b0, 5'(NCH - 1), 8'h01};
                A_GCFG:   bus_rdata = {30'b0, leg_q, run_q};
                A_STAT:   bus_rdata = WORD'(status_q);
                A_CNT_LO: bus_rdata = cnt[WORD-1:0];
                A_CNT_HI: bus_rdata = cnt[CNT_W-1:WORD];
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R8: a set status bit survives until it is written with a 1
    p_level_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (|(status_q & ~clr_mask)) |=> (($past(status_q & ~clr_mask) & ~status_q) == '0));

    // R10: a message-routed match turns into a request one cycle later
    p_msg_follow_r10: assert property (@(posedge clk) disable iff (rst)
        ((hit_v & to_msg) != '0) |=> msg_valid_o);
endmodule

// File: tb/evtimer_top_bench.sv
module evtimer_top_bench;
    localparam int CLK_P = 10;
    localparam int NCH   = 3;

    localparam logic [11:0] ID = 12'h000, GCFG = 12'h010, STAT = 12'h020;
    localparam logic [11:0] CLO = 12'h0F0, CHI = 12'h0F4;

    logic        clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NCH-1:0] irq_o;
    logic leg_tick_o, leg_rtc_o, msg_valid_o;
    logic [31:0] msg_addr_o, msg_data_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    int          hits  [7];
    logic [31:0] first [7];
    logic [31:0] mdat [4], madr [4], mcnt [4];
    int          nm;

    always #(CLK_P/2) clk = ~clk;

    evtimer_top u_evtimer_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .leg_tick_o(leg_tick_o), .leg_rtc_o(leg_rtc_o),
        .msg_valid_o(msg_valid_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
    );

    function automatic logic [11:0] chr(int n, int off);
        return 12'(12'h100 + 32 * n + off);
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // samples every cycle; index 0..2 lines, 3 tick, 4 rtc, 5 message
    task automatic watch(int n);
        logic [5:0] s;
        bus_addr = CLO;
        nm = 0;
        for (int i = 0; i < 7; i++) begin hits[i] = 0; first[i] = '0; end
        for (int k = 0; k < n; k++) begin
            #1;
            s = {msg_valid_o, leg_rtc_o, leg_tick_o, irq_o};
            for (int i = 0; i < 6; i++) begin
                if (s[i]) begin
                    if (hits[i] == 0) first[i] = bus_rdata;
                    hits[i]++;
                end
            end
            if (msg_valid_o && nm < 4) begin
                mdat[nm] = msg_data_o; madr[nm] = msg_addr_o; mcnt[nm] = bus_rdata; nm++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] a, b;
        do_reset();

        // R1 reset state
        rd(ID, a);  chk("R1 id register", a, 32'h0000_0201);
        rd(CLO, a); chk("R1 counter reset", a, 0);
        chk("R1 lines low", {29'b0, irq_o, 1'b0} | {30'b0, leg_tick_o, leg_rtc_o}, 0);
        chk("R1 message idle", msg_valid_o, 0);

        // R2 stopped writes, dropped running writes
        wr(CLO, 32'h1234); wr(CHI, 32'hABCD);
        rd(CLO, a); chk("R2 counter low write", a, 32'h1234);
        rd(CHI, a); chk("R2 counter high write", a, 32'hABCD);
        wr(GCFG, 1);
        // R3 one step per cycle
        rd(CLO, a); @(negedge clk); #1 b = bus_rdata;
        chk("R3 counter step", b - a, 1);
        wr(CLO, 0); wr(CHI, 0); wr(GCFG, 0);
        rd(CLO, a); chk("R2 running low write dropped", a >= 32'h1234, 1);
        rd(CHI, a); chk("R2 running high write dropped", a, 32'hABCD);

        // R5 one-shot edge
        do_reset();
        wr(CLO, 32'h100); wr(chr(0, 8), 32'h110); wr(chr(0, 0), 32'h4);
        rd(chr(0, 8), a); chk("R5 comparator readback", a, 32'h110);
        rd(chr(0, 0), a); chk("R4 channel 0 config", a, 32'h0000_0014);
        wr(GCFG, 1); watch(40);
        chk("R5 one-shot pulse count", hits[0], 1);
        chk("R5 pulse after match", first[0], 32'h111);

        // R6 periodic with set-value
        do_reset();
        wr(chr(1, 0), 32'h4C);
        rd(chr(1, 0), a); chk("R6 config with setval reads 0", a, 32'h0000_801C);
        wr(chr(1, 8), 32'h20); wr(chr(1, 8), 32'h10);
        rd(chr(1, 8), a); chk("R6 first write is comparator", a, 32'h20);
        wr(GCFG, 1); watch(32'h58); wr(GCFG, 0);
        chk("R6 periodic pulse count", hits[1], 4);
        chk("R6 first periodic pulse", first[1], 32'h21);
        rd(chr(1, 8), a); chk("R6 comparator advanced by period", a, 32'h60);

        // R7 no periodic capability
        do_reset();
        wr(chr(2, 0), 32'hC);
        rd(chr(2, 0), a); chk("R7 periodic bit ignored", a, 32'h0000_8004);
        wr(chr(2, 8), 32'h8); wr(GCFG, 1); watch(48);
        chk("R7 fires once", hits[2], 1);
        chk("R7 fire point", first[2], 32'h9);

        // R8 level trigger
        do_reset();
        wr(chr(0, 0), 32'h6); wr(chr(0, 8), 32'h5); wr(GCFG, 1); watch(20); wr(GCFG, 0);
        chk("R8 level held samples", hits[0], 14);
        chk("R8 level rise", first[0], 32'h6);
        rd(STAT, a); chk("R8 status bit set", a, 1);
        chk("R8 line still high", irq_o[0], 1);
        wr(STAT, 1);
        rd(STAT, a); chk("R8 status cleared", a, 0);
        chk("R8 line low after clear", irq_o[0], 0);

        // R9 legacy routing
        do_reset();
        wr(GCFG, 2);
        wr(chr(0, 0), 32'h4); wr(chr(0, 8), 32'h4);
        wr(chr(1, 0), 32'h4); wr(chr(1, 8), 32'h7);
        wr(GCFG, 3); watch(16);
        chk("R9 tick line count", hits[3], 1);
        chk("R9 tick line point", first[3], 32'h5);
        chk("R9 rtc line count", hits[4], 1);
        chk("R9 rtc line point", first[4], 32'h8);
        chk("R9 own lines quiet", hits[0] + hits[1], 0);

        // R10, R11 message delivery
        do_reset();
        wr(chr(0, 0), 32'h4004); wr(chr(0, 8), 32'h10);
        wr(chr(1, 0), 32'h4004); wr(chr(1, 8), 32'h10);
        wr(chr(1, 16), 32'hAAAA0001); wr(chr(1, 20), 32'hFEE00010);
        wr(chr(2, 0), 32'h4004); wr(chr(2, 8), 32'h10);
        wr(chr(2, 16), 32'hBBBB0002); wr(chr(2, 20), 32'hFEE00020);
        rd(chr(0, 0), a); chk("R10 message bit ignored without capability", a, 32'h0000_0014);
        wr(GCFG, 1); watch(32);
        chk("R10 lines quiet for message channels", hits[1] + hits[2], 0);
        chk("R10 non-capable channel uses line", hits[0], 1);
        chk("R11 two requests", hits[5], 2);
        chk("R11 first data", mdat[0], 32'hAAAA0001);
        chk("R10 first address", madr[0], 32'hFEE00010);
        chk("R11 first cycle", mcnt[0], 32'h11);
        chk("R11 second data", mdat[1], 32'hBBBB0002);
        chk("R11 second address", madr[1], 32'hFEE00020);
        chk("R11 second cycle", mcnt[1], 32'h12);

        // R12 32-bit compare
        do_reset();
        wr(CLO, 32'h10); wr(CHI, 32'h5);
        wr(chr(0, 0), 32'h104); wr(chr(0, 8), 32'h18);
        wr(chr(1, 0), 32'h4);   wr(chr(1, 8), 32'h18);
        wr(GCFG, 1); watch(20);
        chk("R12 low-half match fires", hits[0], 1);
        chk("R12 low-half match point", first[0], 32'h19);
        chk("R12 full compare does not fire", hits[1], 0);

        // R13 comparator behind counter
        do_reset();
        wr(CLO, 32'h40); wr(chr(0, 0), 32'h4); wr(chr(0, 8), 32'h20);
        wr(GCFG, 1); watch(40);
        chk("R13 passed comparator silent", hits[0], 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule